// File: doc/BRIEF.md
# Register Rename Map with Free List

This block turns the architectural register names of one instruction per cycle into physical register names. Instructions reach it at dispatch, in program order. Both source operands are looked up in a map table that holds one entry for each architectural register. Every instruction that writes a register takes a fresh physical register from the head of a free-list FIFO. The map entry for its destination is then pointed at that new register. The response also returns the physical register that the destination named before the update. The pipeline carries this value along and hands it back through the commit port once the overwriting instruction retires. That hand-back is the only way a physical register returns to the free list.

The rename request is a valid/ready stream. The response is combinational, in the same cycle as the request: `rsp_valid` is high exactly when `req_valid` and `req_ready` are both high, and only an accepted request changes state. The block pulls `req_ready` low only when the request needs a new register and the free list is empty at the start of that cycle. While `req_ready` is low, the source must hold the request. A request that needs no new register is always accepted. `stall` is `req_valid` and not `req_ready`, and it is provided for dispatch control. The commit port has no back-pressure, and a returned register joins the tail of the FIFO at the next edge.

Top module: `rename_map_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The free list then holds physical registers 32 to 63, with 32 at the head.
- R2: Sources are looked up before the destination is remapped. A source that names the instruction's own destination returns the mapping from before this instruction.
- R3: Each allocation takes the physical register at the head of the free list, in FIFO order. The first allocations after reset return 32, 33, 34 and so on.
- R4: On an allocation, `rsp_old_pdst` returns the physical register that the destination held before the update, and `rsp_pdst` differs from it.
- R5: A later instruction that reads an architectural register receives the physical register most recently allocated to it.
- R6: Architectural register 0 is never renamed. A destination of 0 allocates nothing, and a source of 0 always returns physical 0.
- R7: A request with `req_dst_en` low allocates nothing and leaves the free list unchanged. With no allocation, `rsp_pdst` and `rsp_old_pdst` are 0.
- R8: When a request needs a register and the free list is empty, `req_ready` is low, `stall` is high and `rsp_valid` is low, and no state changes. A request that needs no register is still accepted.
- R9: A committed register goes to the tail of the free list. It is handed out again only after every register that was queued before it.
- R10: A commit and an allocation in the same cycle both take effect, and no register is lost. A commit arriving while a request is stalled becomes usable in the next cycle.
- R11: `rsp_valid` equals `req_valid` and `req_ready`. A cycle with `req_valid` low changes no mapping and consumes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Rename request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_src1 | input | 5 | First source architectural register |
| req_src2 | input | 5 | Second source architectural register |
| req_dst | input | 5 | Destination architectural register |
| req_dst_en | input | 1 | Instruction writes a destination |
| rsp_valid | output | 1 | Response valid (accepted request) |
| rsp_psrc1 | output | 6 | Physical register for source 1 |
| rsp_psrc2 | output | 6 | Physical register for source 2 |
| rsp_pdst | output | 6 | Newly allocated physical register, 0 if none |
| rsp_old_pdst | output | 6 | Previous mapping of the destination, 0 if none |
| stall | output | 1 | Request held for lack of a free register |
| cmt_valid | input | 1 | Commit returns a physical register |
| cmt_preg | input | 6 | Physical register being freed |

## Verification
Some rules are checked on every cycle. The free-count bookkeeping must hold for allocations, commits and both together. A request that needs a register while the list is empty must stall. The handshake must be consistent, and register 0 must stay fixed. A new register must never equal the one it replaces, and a source read right after an allocation must see that allocation. Other behaviour can only be shown by the bench's scenarios. These are the exact FIFO order of returned registers and correct old mappings over a long chain of rewrites. They also include recovery after the list runs dry, and the reset image of the table after renaming has taken place.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int DEF_ARCH_REGS = 32;
  localparam int DEF_PHYS_REGS = 64;

  function automatic int unsigned idx_bits(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rename_map_table.sv
module rename_map_table #(
  parameter int NUM_ARCH = rename_pkg::DEF_ARCH_REGS,
  parameter int PW       = 6,
  localparam int AW      = rename_pkg::idx_bits(NUM_ARCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a_idx,
  input  logic [AW-1:0] rd_b_idx,
  input  logic [AW-1:0] rd_c_idx,
  output logic [PW-1:0] rd_a_val,
  output logic [PW-1:0] rd_b_val,
  output logic [PW-1:0] rd_c_val,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [PW-1:0] wr_val
);
  logic [PW-1:0] entry [NUM_ARCH];

  for (genvar e = 0; e < NUM_ARCH; e++) begin : g_entry
    if (e == 0) begin : g_zero
      // architectural zero is pinned to physical zero
      assign entry[e] = '0;
    end else begin : g_live
      always_ff @(posedge clk) begin
        if (!rst_n)
          entry[e] <= PW'(e);
        else if (wr_en && (wr_idx == AW'(e)))
          entry[e] <= wr_val;
      end
    end
  end

  // reads see the table as it was before this cycle's write
  assign rd_a_val = entry[rd_a_idx];
  assign rd_b_val = entry[rd_b_idx];
  assign rd_c_val = entry[rd_c_idx];
endmodule

// File: rtl/rename_free_fifo.sv
module rename_free_fifo #(
  parameter int DEPTH = 32,
  parameter int FIRST = 32,
  parameter int PW    = 6,
  localparam int IW   = rename_pkg::idx_bits(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  output logic [PW-1:0] head,
  output logic          empty,
  input  logic          push,
  input  logic [PW-1:0] push_val,
  output logic [CW-1:0] count
);
  logic [PW-1:0] slot [DEPTH];
  logic [IW-1:0] rd_ptr, wr_ptr;
  logic          do_pop, do_push;

  function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign head    = slot[rd_ptr];
  assign do_pop  = pop && !empty;
  assign do_push = push && ((count != CW'(DEPTH)) || do_pop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= PW'(FIRST + i);
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= CW'(DEPTH);
    end else begin
      if (do_push) begin
        slot[wr_ptr] <= push_val;
        wr_ptr       <= bump(wr_ptr);
      end
      if (do_pop) rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rename_map_unit.sv
module rename_map_unit #(
  parameter int NUM_ARCH = rename_pkg::DEF_ARCH_REGS,
  parameter int NUM_PHYS = rename_pkg::DEF_PHYS_REGS,
  localparam int AW      = rename_pkg::idx_bits(NUM_ARCH),
  localparam int PW      = rename_pkg::idx_bits(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_src1,
  input  logic [AW-1:0] req_src2,
  input  logic [AW-1:0] req_dst,
  input  logic          req_dst_en,
  output logic          rsp_valid,
  output logic [PW-1:0] rsp_psrc1,
  output logic [PW-1:0] rsp_psrc2,
  output logic [PW-1:0] rsp_pdst,
  output logic [PW-1:0] rsp_old_pdst,
  output logic          stall,
  input  logic          cmt_valid,
  input  logic [PW-1:0] cmt_preg
);
  localparam int FREE_N = NUM_PHYS - NUM_ARCH;
  localparam int CW     = $clog2(FREE_N + 1);

  logic          needs_reg, list_empty, take;
  logic [PW-1:0] head_reg, cur_dst_map;
  logic [CW-1:0] free_cnt;

  assign needs_reg = req_dst_en && (req_dst != '0);
  assign req_ready = !(needs_reg && list_empty);
  assign rsp_valid = req_valid && req_ready;
  assign stall     = req_valid && !req_ready;
  assign take      = rsp_valid && needs_reg;

  rename_map_table #(.NUM_ARCH(NUM_ARCH), .PW(PW)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (req_src1),
    .rd_b_idx (req_src2),
    .rd_c_idx (req_dst),
    .rd_a_val (rsp_psrc1),
    .rd_b_val (rsp_psrc2),
    .rd_c_val (cur_dst_map),
    .wr_en    (take),
    .wr_idx   (req_dst),
    .wr_val   (head_reg)
  );

  rename_free_fifo #(.DEPTH(FREE_N), .FIRST(NUM_ARCH), .PW(PW)) u_free (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop      (take),
    .head     (head_reg),
    .empty    (list_empty),
    .push     (cmt_valid),
    .push_val (cmt_preg),
    .count    (free_cnt)
  );

  assign rsp_pdst     = take ? head_reg    : '0;
  assign rsp_old_pdst = take ? cur_dst_map : '0;
endmodule

// File: rtl/rename_map_checker.sv
module rename_map_checker #(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 64,
  localparam int AW      = rename_pkg::idx_bits(NUM_ARCH),
  localparam int PW      = rename_pkg::idx_bits(NUM_PHYS),
  localparam int FREE_N  = NUM_PHYS - NUM_ARCH,
  localparam int CW      = $clog2(FREE_N + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_src1,
  input logic [AW-1:0] req_dst,
  input logic          req_dst_en,
  input logic          rsp_valid,
  input logic [PW-1:0] rsp_psrc1,
  input logic [PW-1:0] rsp_pdst,
  input logic [PW-1:0] rsp_old_pdst,
  input logic          stall,
  input logic          cmt_valid,
  input logic [CW-1:0] free_cnt
);
  logic wants, got;
  assign wants = req_valid && req_dst_en && (req_dst != '0);
  assign got   = rsp_valid && req_dst_en && (req_dst != '0);

  p_handshake_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (req_valid && req_ready && !stall));

  p_stall_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wants && free_cnt == '0) |-> (stall && !req_ready && !rsp_valid));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !cmt_valid) |=> $stable(free_cnt));

  p_alloc_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (got && !cmt_valid) |=> (free_cnt == $past(free_cnt) - 1'b1));

  p_both_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (got && cmt_valid) |=> $stable(free_cnt));

  p_fresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
    got |-> (rsp_pdst != rsp_old_pdst));

  p_zero_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && req_src1 == '0) |-> (rsp_psrc1 == '0));

  p_noalloc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !got) |-> (rsp_pdst == '0 && rsp_old_pdst == '0));

  p_newmap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(got) && rsp_valid && req_src1 == $past(req_dst)) |-> (rsp_psrc1 == $past(rsp_pdst)));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |-> ((free_cnt < CW'(FREE_N)) || got));
endmodule

bind rename_map_unit rename_map_checker #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_src1     (req_src1),
  .req_dst      (req_dst),
  .req_dst_en   (req_dst_en),
  .rsp_valid    (rsp_valid),
  .rsp_psrc1    (rsp_psrc1),
  .rsp_pdst     (rsp_pdst),
  .rsp_old_pdst (rsp_old_pdst),
  .stall        (stall),
  .cmt_valid    (cmt_valid),
  .free_cnt     (free_cnt)
);

// File: tb/tb_rename_map_unit.sv
module tb_rename_map_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [4:0] s1, s2, d;
    logic       de, cv;
    logic [5:0] cp, e1, e2, ep, eo;
  } vec_t;

  // rows: src1 src2 dst dst_en cmt cmt_preg | exp psrc1 psrc2 pdst old
  localparam vec_t VEC [6] = '{
    '{5'd1, 5'd2,  5'd3,  1'b1, 1'b0, 6'd0, 6'd1,  6'd2,  6'd32, 6'd3 },  // R3 R4
    '{5'd3, 5'd3,  5'd3,  1'b1, 1'b0, 6'd0, 6'd32, 6'd32, 6'd33, 6'd32},  // R2 R5
    '{5'd3, 5'd0,  5'd0,  1'b1, 1'b0, 6'd0, 6'd33, 6'd0,  6'd0,  6'd0 },  // R6
    '{5'd5, 5'd3,  5'd5,  1'b0, 1'b0, 6'd0, 6'd5,  6'd33, 6'd0,  6'd0 },  // R7
    '{5'd5, 5'd4,  5'd4,  1'b1, 1'b1, 6'd3, 6'd5,  6'd4,  6'd34, 6'd4 },  // R10
    '{5'd4, 5'd31, 5'd31, 1'b1, 1'b0, 6'd0, 6'd34, 6'd31, 6'd35, 6'd31}   // R5 R7
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_dst_en = 0, cmt_valid = 0;
  logic [4:0] req_src1 = 0, req_src2 = 0, req_dst = 0;
  logic [5:0] cmt_preg = 0;
  logic req_ready, rsp_valid, stall;
  logic [5:0] rsp_psrc1, rsp_psrc2, rsp_pdst, rsp_old_pdst;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rename_map_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_src1(req_src1), .req_src2(req_src2), .req_dst(req_dst), .req_dst_en(req_dst_en),
    .rsp_valid(rsp_valid), .rsp_psrc1(rsp_psrc1), .rsp_psrc2(rsp_psrc2),
    .rsp_pdst(rsp_pdst), .rsp_old_pdst(rsp_old_pdst), .stall(stall),
    .cmt_valid(cmt_valid), .cmt_preg(cmt_preg)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int s1, input int s2, input int d,
                       input logic de, input logic cv, input int cp);
    @(negedge clk);
    req_valid = v; req_src1 = 5'(s1); req_src2 = 5'(s2); req_dst = 5'(d);
    req_dst_en = de; cmt_valid = cv; cmt_preg = 6'(cp);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; req_valid = 0; cmt_valid = 0; req_dst_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int prev;
    do_reset();
    // R1: identity mapping, nothing pending
    drive(0, 17, 31, 0, 0, 0, 0);
    chk("R1 psrc1", rsp_psrc1, 17);
    chk("R1 psrc2", rsp_psrc2, 31);
    chk("R11 idle valid", rsp_valid, 0);
    chk("R1 stall", stall, 0);

    foreach (VEC[i]) begin
      drive(1, VEC[i].s1, VEC[i].s2, VEC[i].d, VEC[i].de, VEC[i].cv, VEC[i].cp);
      chk($sformatf("vec%0d psrc1", i), rsp_psrc1, VEC[i].e1);
      chk($sformatf("vec%0d psrc2", i), rsp_psrc2, VEC[i].e2);
      chk($sformatf("vec%0d pdst", i), rsp_pdst, VEC[i].ep);
      chk($sformatf("vec%0d old", i), rsp_old_pdst, VEC[i].eo);
      chk($sformatf("vec%0d valid R11", i), rsp_valid, 1);
    end

    // R11: invalid request consumes nothing
    drive(0, 0, 0, 9, 1, 0, 0);
    chk("R11 no valid", rsp_valid, 0);
    chk("R11 no pdst", rsp_pdst, 0);

    // R3/R4: drain the list through r7; head must be 36 (no loss from idle cycle)
    prev = 7;
    for (int k = 0; k < 28; k++) begin
      drive(1, 7, 0, 7, 1, 0, 0);
      chk("R3 drain pdst", rsp_pdst, 36 + k);
      chk("R4 drain old", rsp_old_pdst, prev);
      chk("R5 drain src", rsp_psrc1, prev);
      prev = 36 + k;
    end
    // R9: register committed earlier comes out after the original entries
    drive(1, 0, 0, 7, 1, 0, 0);
    chk("R9 tail order", rsp_pdst, 3);
    chk("R4 old", rsp_old_pdst, 63);

    // R8: empty list
    drive(1, 0, 0, 7, 1, 0, 0);
    chk("R8 stall", stall, 1);
    chk("R8 ready", req_ready, 0);
    chk("R8 valid", rsp_valid, 0);
    drive(1, 7, 0, 7, 0, 0, 0);
    chk("R8 no-dst accepted", rsp_valid, 1);
    chk("R5 src after drain", rsp_psrc1, 3);
    // R10: commit while stalled
    drive(1, 0, 0, 9, 1, 1, 50);
    chk("R10 stalled with commit", stall, 1);
    drive(1, 0, 0, 9, 1, 0, 0);
    chk("R10 commit usable", rsp_pdst, 50);
    chk("R4 old r9", rsp_old_pdst, 9);
    drive(1, 9, 0, 0, 0, 0, 0);
    chk("R5 r9 map", rsp_psrc1, 50);
    chk("R8 stall persists", stall, 0);

    // R10: commit and allocate in same cycle, nothing lost
    drive(0, 0, 0, 0, 0, 1, 40);
    drive(0, 0, 0, 0, 0, 1, 41);
    drive(1, 0, 0, 11, 1, 1, 42);
    chk("R10 same-cycle pdst", rsp_pdst, 40);
    drive(1, 0, 0, 12, 1, 0, 0);
    chk("R10 next pdst", rsp_pdst, 41);
    drive(1, 0, 0, 13, 1, 0, 0);
    chk("R10 committed kept", rsp_pdst, 42);
    drive(1, 0, 0, 14, 1, 0, 0);
    chk("R8 empty again", stall, 1);

    // R1/R3: reset restores identity and the free order
    do_reset();
    drive(1, 7, 9, 1, 1, 0, 0);
    chk("R1 r7 after reset", rsp_psrc1, 7);
    chk("R1 r9 after reset", rsp_psrc2, 9);
    chk("R3 first after reset", rsp_pdst, 32);
    chk("R4 old after reset", rsp_old_pdst, 1);
    drive(0, 0, 0, 0, 0, 0, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule